// File: doc/BRIEF.md
# Three-Wire Serial Clock and NVRAM Slave

This block is the slave end of a three-wire, bit-banged serial link to a real-time clock that also holds a small byte-wide configuration memory. A host toggles an enable, a serial clock and a data bit from a control register. The block watches these levels with its own system clock and acts on every falling edge of the serial clock while the enable is high.

Each transaction carries an 8-bit command, most significant bit first, followed by an 8-bit data byte. The command code decides what the data phase does:
- read a memory byte;
- write a memory byte;
- read one BCD time-of-day field;
- read the status byte;
- clear two status bits, with a one-cycle strobe to the power-interrupt logic.

A once-per-second tick advances the time registers with BCD carries. A parallel preset port loads all six time fields at once.

Top module: `rtc_serial_slave`

## Requirements
- R1: While `ce` is 1, each 1-to-0 transition of `sclk` samples `sdi`. The first eight samples form the command, most significant bit first, and the next eight form the data byte, most significant bit first.
- R2: Commands 0x00 to 0x1F read memory byte [command]. After the k-th falling edge of the transaction (k = 9 to 16), `sdo` holds bit 16-k of that byte.
- R3: Commands 0x80 to 0x9F write the received data byte to memory location command-0x80 when the 16th falling edge is seen. A transaction that ends earlier writes nothing.
- R4: `ce` at 0 returns the phase count, the command and the received value to zero, so the next transaction decodes from its first bit.
- R5: The status byte resets to 0x90 and is read with command 0x30. Command 0x31 reads as 0x00.
- R6: The time fields are read in packed BCD, with tens in bits 7:4, using these commands: 0x20 seconds, 0x21 minutes, 0x22 hours, 0x24 day, 0x25 month, 0x26 two-digit year. The other codes in 0x20 to 0x2F read 0x00.
- R7: A `tick` pulse adds one second. Carries ripple through minutes (00-59), hours (00-23), day (01 to month length), month (01-12) and year (00-99). Months have fixed lengths, and February has FEB_DAYS days (default 28).
- R8: Command 0xB1 with data bit 2 set clears status bits 3 and 4 and pulses `pwr_clr` for exactly one clock. With data bit 2 clear it changes nothing and gives no pulse.
- R9: `preset_en` loads `preset_time` into all fields in one clock, with priority over `tick`. The layout is year [47:40], month [39:32], day [31:24], hours [23:16], minutes [15:8], seconds [7:0].
- R10: Falling edges after the 16th have no effect. Commands outside the read ranges drive `sdo` as 0 during the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Serial transaction enable |
| sclk | input | 1 | Serial clock level from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data toward the host |
| tick | input | 1 | One-second advance pulse |
| preset_en | input | 1 | Load the time fields from `preset_time` |
| preset_time | input | 48 | Parallel BCD time image |
| pwr_clr | output | 1 | One-clock strobe clearing power-interrupt status |

## Verification
Memory is written and read back with bytes of different shapes, so that a bit-order or off-by-one-phase fault changes the value seen:
- alternating bits;
- all ones;
- a mid pattern;
- the first and last addresses.

Transactions cut short in the command phase and in the data phase show whether a write escapes early and whether the phase count restarts. Extra falling edges after the 16th show whether a write can land twice. Time reads cover every code in the group, including the unused ones. Two presets just before a rollover, one at year end and one at the end of February, show whether the carry chain and the month-length choice are right.

// File: rtl/rtc_serial_pkg.sv
package rtc_serial_pkg;
   localparam int CMD_BITS  = 8;
   localparam int DATA_BITS = 8;
   localparam int XFER_BITS = CMD_BITS + DATA_BITS;

   localparam logic [7:0] CMD_STAT_RD  = 8'h30;
   localparam logic [7:0] CMD_STAT_AUX = 8'h31;
   localparam logic [7:0] CMD_STAT_CLR = 8'hB1;
   localparam logic [7:0] CMD_WR_BASE  = 8'h80;
   localparam logic [3:0] TIME_GROUP   = 4'h2;
   localparam logic [7:0] STAT_CLR_MSK = 8'h18;

   typedef struct packed {
      logic [7:0] year;
      logic [7:0] month;
      logic [7:0] day;
      logic [7:0] hour;
      logic [7:0] minute;
      logic [7:0] second;
   } bcd_time_t;

   // BCD increment that wraps from hi back to lo
   function automatic logic [7:0] bcd_inc(input logic [7:0] v,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
      logic [7:0] r;
      if (v == hi)             r = lo;
      else if (v[3:0] == 4'h9) r = {v[7:4] + 4'h1, 4'h0};
      else                     r = v + 8'h01;
      return r;
   endfunction

   // last day of a BCD month, February given by the caller
   function automatic logic [7:0] month_last(input logic [7:0] m,
                                             input logic [7:0] feb);
      logic [7:0] r;
      case (m)
         8'h02:                      r = feb;
         8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
         default:                    r = 8'h31;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/rtc_serial_front.sv
module rtc_serial_front
   import rtc_serial_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ce,
   input  logic                sclk,
   input  logic                sdi,
   input  logic [DATA_BITS-1:0] rd_byte,
   output logic [CMD_BITS-1:0] cmd,
   output logic                commit,
   output logic [DATA_BITS-1:0] commit_data,
   output logic                sdo
);
   localparam int PW = $clog2(XFER_BITS + 1);

   logic                 sclk_q;
   logic                 fall;
   logic [PW-1:0]        phase;
   logic [DATA_BITS-1:0] rx_val;
   logic [2:0]           bit_idx;

   assign fall        = ce & sclk_q & ~sclk;
   assign bit_idx     = 3'(XFER_BITS - 1 - int'(phase));
   assign commit      = fall && (phase == PW'(XFER_BITS - 1));
   assign commit_data = {rx_val[DATA_BITS-2:0], sdi};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         phase  <= '0;
         cmd    <= '0;
         rx_val <= '0;
         sdo    <= 1'b0;
      end else begin
         sclk_q <= sclk;
         if (!ce) begin
            phase  <= '0;
            cmd    <= '0;
            rx_val <= '0;
            sdo    <= 1'b0;
         end else if (fall) begin
            if (phase < PW'(CMD_BITS)) begin
               cmd <= {cmd[CMD_BITS-2:0], sdi};
            end else if (phase < PW'(XFER_BITS)) begin
               rx_val <= {rx_val[DATA_BITS-2:0], sdi};
               sdo    <= rd_byte[bit_idx];
            end
            if (phase < PW'(XFER_BITS)) phase <= phase + PW'(1);
         end
      end
   end

   AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> (phase == '0 && cmd == '0 && rx_val == '0)); // R4
   AST_PHASE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= PW'(XFER_BITS)); // R10
   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !fall) |=> $stable(phase)); // R1
endmodule

// File: rtl/rtc_nvram_status.sv
module rtc_nvram_status
   import rtc_serial_pkg::*;
#(
   parameter int          RAM_BYTES   = 32,
   parameter logic [7:0]  STATUS_INIT = 8'h90,
   localparam int         AW          = $clog2(RAM_BYTES)
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        commit,
   input  logic [7:0]  cmd,
   input  logic [7:0]  wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]  rd_data,
   output logic [7:0]  status,
   output logic        pwr_clr
);
   logic [7:0] mem [RAM_BYTES];
   logic       wr_hit;
   logic       clr_hit;

   assign wr_hit  = commit && (cmd >= CMD_WR_BASE) &&
                    (cmd < CMD_WR_BASE + 8'(RAM_BYTES));
   assign clr_hit = commit && (cmd == CMD_STAT_CLR) && wr_data[2];
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < RAM_BYTES; i++) mem[i] <= 8'h00;
         status  <= STATUS_INIT;
         pwr_clr <= 1'b0;
      end else begin
         pwr_clr <= 1'b0;
         if (wr_hit) mem[cmd[AW-1:0]] <= wr_data;
         if (clr_hit) begin
            status  <= status & ~STAT_CLR_MSK;
            pwr_clr <= 1'b1;
         end
      end
   end

   AST_PWR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_clr |=> !pwr_clr); // R8
   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(status)); // R8
   AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_clr |-> (status & STAT_CLR_MSK) == 8'h00); // R8
endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
   import rtc_serial_pkg::*;
#(
   parameter int FEB_DAYS = 28
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      preset_en,
   input  bcd_time_t preset_time,
   output bcd_time_t now
);
   logic [7:0] feb_last;
   logic [7:0] day_last;
   logic c_min, c_hour, c_day, c_mon, c_year;

   generate
      if (FEB_DAYS == 29) begin : g_feb29
         assign feb_last = 8'h29;
      end else begin : g_feb28
         assign feb_last = 8'h28;
      end
   endgenerate

   assign day_last = month_last(now.month, feb_last);
   assign c_min  = (now.second == 8'h59);
   assign c_hour = c_min  && (now.minute == 8'h59);
   assign c_day  = c_hour && (now.hour == 8'h23);
   assign c_mon  = c_day  && (now.day == day_last);
   assign c_year = c_mon  && (now.month == 8'h12);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now <= '{year: 8'h00, month: 8'h01, day: 8'h01,
                  hour: 8'h00, minute: 8'h00, second: 8'h00};
      end else if (preset_en) begin
         now <= preset_time;
      end else if (tick) begin
         now.second <= bcd_inc(now.second, 8'h00, 8'h59);
         if (c_min)  now.minute <= bcd_inc(now.minute, 8'h00, 8'h59);
         if (c_hour) now.hour   <= bcd_inc(now.hour, 8'h00, 8'h23);
         if (c_day)  now.day    <= bcd_inc(now.day, 8'h01, day_last);
         if (c_mon)  now.month  <= bcd_inc(now.month, 8'h01, 8'h12);
         if (c_year) now.year   <= bcd_inc(now.year, 8'h00, 8'h99);
      end
   end

   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !preset_en && now.second == 8'h59) |=> now.second == 8'h00); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !preset_en) |=> $stable(now)); // R7
   AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      preset_en |=> now == $past(preset_time)); // R9
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
   import rtc_serial_pkg::*;
#(
   parameter int         RAM_BYTES   = 32,
   parameter int         FEB_DAYS    = 28,
   parameter logic [7:0] STATUS_INIT = 8'h90
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ce,
   input  logic        sclk,
   input  logic        sdi,
   output logic        sdo,
   input  logic        tick,
   input  logic        preset_en,
   input  logic [47:0] preset_time,
   output logic        pwr_clr
);
   localparam int AW = $clog2(RAM_BYTES);

   if (RAM_BYTES < 2 || RAM_BYTES > 32 || (RAM_BYTES & (RAM_BYTES - 1)) != 0) begin : g_bad_ram
      $error("RAM_BYTES must be a power of two from 2 to 32");
   end
   if (FEB_DAYS != 28 && FEB_DAYS != 29) begin : g_bad_feb
      $error("FEB_DAYS must be 28 or 29");
   end

   logic [7:0] cmd;
   logic       commit;
   logic [7:0] commit_data;
   logic [7:0] rd_byte;
   logic [7:0] mem_rd;
   logic [7:0] status;
   bcd_time_t  now;

   rtc_serial_front u_front (
      .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdi(sdi),
      .rd_byte(rd_byte), .cmd(cmd), .commit(commit),
      .commit_data(commit_data), .sdo(sdo)
   );

   rtc_nvram_status #(.RAM_BYTES(RAM_BYTES), .STATUS_INIT(STATUS_INIT)) u_mem (
      .clk(clk), .rst_n(rst_n), .commit(commit), .cmd(cmd),
      .wr_data(commit_data), .rd_addr(cmd[AW-1:0]), .rd_data(mem_rd),
      .status(status), .pwr_clr(pwr_clr)
   );

   rtc_bcd_clock #(.FEB_DAYS(FEB_DAYS)) u_clock (
      .clk(clk), .rst_n(rst_n), .tick(tick), .preset_en(preset_en),
      .preset_time(bcd_time_t'(preset_time)), .now(now)
   );

   always_comb begin
      rd_byte = 8'h00;
      if (cmd < 8'(RAM_BYTES)) begin
         rd_byte = mem_rd;
      end else if (cmd == CMD_STAT_RD) begin
         rd_byte = status;
      end else if (cmd == CMD_STAT_AUX) begin
         rd_byte = 8'h00;
      end else if (cmd[7:4] == TIME_GROUP) begin
         case (cmd[3:0])
            4'h0:    rd_byte = now.second;
            4'h1:    rd_byte = now.minute;
            4'h2:    rd_byte = now.hour;
            4'h4:    rd_byte = now.day;
            4'h5:    rd_byte = now.month;
            4'h6:    rd_byte = now.year;
            default: rd_byte = 8'h00;
         endcase
      end
   end

   AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |-> !commit); // R3
endmodule

// File: tb/sim_rtc_serial_slave.sv
module sim_rtc_serial_slave;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
   logic        tick = 1'b0, preset_en = 1'b0;
   logic [47:0] preset_time = '0;
   logic        sdo, pwr_clr;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] got_byte;
   event       got_ev;

   always #10 clk = ~clk;

   rtc_serial_slave u0 (
      .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdi(sdi), .sdo(sdo),
      .tick(tick), .preset_en(preset_en), .preset_time(preset_time),
      .pwr_clr(pwr_clr)
   );

   always @(posedge clk) if (rst_n && pwr_clr) pulses++;

   task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data as results arrive
   initial begin
      forever begin
         @(got_ev);
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL scoreboard actual=%02h expected=none", got_byte);
         end else begin
            check8(got_byte, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   task automatic send_bit(input logic b);
      @(negedge clk); sdi = b; sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] c, input logic [7:0] w, input int extra,
                       output logic [7:0] r);
      @(negedge clk); ce = 1'b1;
      repeat (2) @(negedge clk);
      for (int i = 7; i >= 0; i--) send_bit(c[i]);
      r = 8'h00;
      for (int i = 7; i >= 0; i--) begin
         send_bit(w[i]);
         r = {r[6:0], sdo};
      end
      for (int i = 0; i < extra; i++) send_bit(1'b1);
      @(negedge clk); ce = 1'b0; sclk = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] c, input logic [7:0] w);
      logic [7:0] r;
      xfer(c, w, 0, r);
   endtask

   task automatic rd_expect(input logic [7:0] c, input logic [7:0] e, input string tag);
      logic [7:0] r;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      xfer(c, 8'h00, 0, r);
      got_byte = r;
      ->got_ev;
      @(negedge clk);
   endtask

   task automatic do_preset(input logic [47:0] t);
      @(negedge clk); preset_time = t; preset_en = 1'b1;
      @(negedge clk); preset_en = 1'b0;
   endtask

   task automatic do_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check8({7'h0, sdo}, 8'h00, "R10 reset sdo");
      check8({7'h0, pwr_clr}, 8'h00, "R8 reset pwr_clr");

      // R5 status and auxiliary status
      rd_expect(8'h30, 8'h90, "R5 status reset");
      rd_expect(8'h31, 8'h00, "R5 aux status");

      // R1 R2 R3 memory write/read patterns
      rd_expect(8'h07, 8'h00, "R2 mem reset");
      wr(8'h80, 8'hA5);
      wr(8'h9F, 8'h3C);
      wr(8'h87, 8'hFF);
      wr(8'h85, 8'h55);
      rd_expect(8'h00, 8'hA5, "R1 R2 addr0");
      rd_expect(8'h1F, 8'h3C, "R2 R3 addr31");
      rd_expect(8'h07, 8'hFF, "R3 addr7");
      rd_expect(8'h05, 8'h55, "R3 addr5");

      // R3 R4 abort in data phase: no write
      @(negedge clk); ce = 1'b1;
      repeat (2) @(negedge clk);
      for (int i = 7; i >= 0; i--) send_bit(8'h85 >> i);
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      @(negedge clk); ce = 1'b0; repeat (2) @(negedge clk);
      rd_expect(8'h05, 8'h55, "R3 aborted write");

      // R4 abort in command phase, next transaction starts fresh
      @(negedge clk); ce = 1'b1;
      repeat (2) @(negedge clk);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      @(negedge clk); ce = 1'b0; repeat (2) @(negedge clk);
      rd_expect(8'h07, 8'hFF, "R4 fresh after abort");

      // R10 extra edges, unmapped command
      begin
         logic [7:0] r;
         xfer(8'h85, 8'h3C, 3, r);
      end
      rd_expect(8'h05, 8'h3C, "R10 extra edges");
      rd_expect(8'h40, 8'h00, "R10 unmapped read");

      // R9 R6 preset and time codes
      do_preset({8'h24, 8'h06, 8'h15, 8'h12, 8'h30, 8'h45});
      rd_expect(8'h20, 8'h45, "R6 R9 seconds");
      rd_expect(8'h21, 8'h30, "R6 minutes");
      rd_expect(8'h22, 8'h12, "R6 hours");
      rd_expect(8'h23, 8'h00, "R6 unused 23");
      rd_expect(8'h24, 8'h15, "R6 day");
      rd_expect(8'h25, 8'h06, "R6 month");
      rd_expect(8'h26, 8'h24, "R6 year");
      rd_expect(8'h2F, 8'h00, "R6 unused 2F");

      // R7 simple tick and full year-end rollover
      do_tick();
      rd_expect(8'h20, 8'h46, "R7 tick");
      do_preset({8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59});
      do_tick();
      rd_expect(8'h20, 8'h00, "R7 yr sec");
      rd_expect(8'h21, 8'h00, "R7 yr min");
      rd_expect(8'h22, 8'h00, "R7 yr hour");
      rd_expect(8'h24, 8'h01, "R7 yr day");
      rd_expect(8'h25, 8'h01, "R7 yr month");
      rd_expect(8'h26, 8'h00, "R7 yr year");
      do_preset({8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59});
      do_tick();
      rd_expect(8'h24, 8'h01, "R7 feb day");
      rd_expect(8'h25, 8'h03, "R7 feb month");
      do_preset({8'h23, 8'h04, 8'h29, 8'h23, 8'h59, 8'h59});
      do_tick();
      rd_expect(8'h24, 8'h30, "R7 april 30");

      // R8 clear command
      wr(8'hB1, 8'h00);
      check8(8'(pulses), 8'h00, "R8 no pulse bit2 clear");
      rd_expect(8'h30, 8'h90, "R8 status kept");
      wr(8'hB1, 8'h04);
      check8(8'(pulses), 8'h01, "R8 one pulse");
      rd_expect(8'h30, 8'h80, "R8 status cleared");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule